// File: doc/BRIEF.md
# Pipeline Hazard Interlock Controller

This block decides, every cycle, whether the instruction in the decode stage of a five-stage in-order integer pipeline may move on into execute. The pipeline has no bypass network, so a dependent instruction can only read its operands from the register file. The block keeps a small shadow of the execute, memory and write-back stages: valid bit, destination, write enable and an occupancy tag. It compares the decode sources against that shadow and drives two separate signals. `stall` freezes fetch and decode and pushes a bubble into execute. `fetch_hold` tells fetch to wait, without predicting, while a branch sits unresolved in decode.

The register file is a write-through model. A write from write-back lands in the first half of a cycle and a decode read happens in the second half, so a value being written is returned to a decode read in the same cycle. For that reason a producer in write-back never causes a stall. Memory accesses complete in one cycle, so every instruction spends exactly one cycle in memory.

The decode slot is a valid/ready stream. `id_valid` marks an instruction in decode and `id_ready` is the low-active form of `stall`. While `id_ready` is low, the upstream stage must present the same instruction again in the next cycle. A transfer into execute happens on any edge where both `id_valid` and `id_ready` are high. Everything else is plain control.

Top module: `interlock_ctrl`

## Requirements
- R1: While reset is active and in the first cycle after it, the execute, memory and write-back valid outputs are low. With no valid decode instruction, `stall` and `fetch_hold` are low.
- R2: `stall` is high when a valid decode instruction has a used source (use flag 1) that is nonzero and equals the destination of a write-enabled instruction in execute.
- R3: `stall` is high when such a source equals the destination of a write-enabled instruction in memory.
- R4: A match only against write-back causes no stall. In that cycle the read data equals `wb_data`. From the next cycle on, the register holds that value.
- R5: Register 0 never causes a stall and always reads as zero.
- R6: In a stalled cycle `id_ready` is low and execute is empty in the next cycle. Otherwise a valid decode instruction appears in execute in the next cycle with its tag.
- R7: `fetch_hold` is high in every cycle in which a valid branch (`id_branch`=1) is in decode, including cycles in which that branch is stalled, and low in all other cycles.
- R8: Without reset, the contents of execute move to memory and the contents of memory move to write-back on every edge, whatever the stall state.
- R9: An instruction with write enable low (for example a store) never causes a stall.
- R10: A source whose use flag is 0 is ignored for hazard checking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_valid | input | 1 | Decode slot holds an instruction |
| id_ready | output | 1 | Decode instruction may advance (not stalled) |
| id_tag | input | 4 | Occupancy tag of the decode instruction |
| id_rs1 | input | 5 | First source register |
| id_rs1_use | input | 1 | First source is read |
| id_rs2 | input | 5 | Second source register |
| id_rs2_use | input | 1 | Second source is read |
| id_rd | input | 5 | Destination register |
| id_we | input | 1 | Instruction writes its destination |
| id_branch | input | 1 | Decode instruction is a branch |
| wb_data | input | 64 | Result written by the instruction in write-back |
| rs1_data | output | 64 | Read data for the first source |
| rs2_data | output | 64 | Read data for the second source |
| stall | output | 1 | Freeze fetch and decode, bubble into execute |
| fetch_hold | output | 1 | Delay fetch while a branch is unresolved |
| ex_valid | output | 1 | Execute stage occupied |
| ex_tag | output | 4 | Tag in execute |
| mem_valid | output | 1 | Memory stage occupied |
| mem_tag | output | 4 | Tag in memory |
| wb_valid | output | 1 | Write-back stage occupied |
| wb_tag | output | 4 | Tag in write-back |

## Verification
The hardest case to reach is a branch that depends on the instruction just ahead of it. The branch must stall for two cycles with `fetch_hold` held through both. It must then leave decode in the cycle its producer writes back, while the decode slot behind it stays empty. The bench reaches this case by replaying a six-instruction load/add/store/subtract/branch loop through the decode port. It follows the stall decision cycle by cycle and checks a hand-derived table of stage occupancy, stall and delayed-fetch values. The loop is repeated into a second iteration. Write-through reads and register 0 get directed sequences in which a single producer is walked through the stages with an idle decode slot.

// File: rtl/ilk_pkg.sv
package ilk_pkg;
  parameter int REG_W  = 5;
  parameter int TAG_W  = 4;
  parameter int DATA_W = 64;
  parameter int NSRC   = 2;
  localparam int NREGS  = 1 << REG_W;
  localparam int NSTAGE = 3;   // execute, memory, write-back

  typedef struct packed {
    logic             valid;
    logic             we;
    logic [REG_W-1:0] rd;
    logic [TAG_W-1:0] tag;
  } stage_t;
endpackage

// File: rtl/ilk_hazard_detect.sv
module ilk_hazard_detect
  import ilk_pkg::*;
(
  input  logic             id_valid,
  input  logic [REG_W-1:0] src_addr [NSRC],
  input  logic             src_use  [NSRC],
  input  stage_t           ex_s,
  input  stage_t           mem_s,
  output logic             stall
);
  logic [NSRC-1:0] hit;

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    logic live, ex_hit, mem_hit;
    always_comb begin
      live    = src_use[s] && (src_addr[s] != '0);
      ex_hit  = ex_s.valid  && ex_s.we  && (ex_s.rd  == src_addr[s]);
      mem_hit = mem_s.valid && mem_s.we && (mem_s.rd == src_addr[s]);
      hit[s]  = live && (ex_hit || mem_hit);
    end
  end

  assign stall = id_valid && (|hit);
endmodule

// File: rtl/ilk_stage_pipe.sv
module ilk_stage_pipe
  import ilk_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   stall,
  input  stage_t id_s,
  output stage_t st [NSTAGE]
);
  stage_t nxt [NSTAGE];

  always_comb begin
    nxt[0] = id_s;
    if (stall || !id_s.valid) nxt[0] = '0;
  end

  for (genvar k = 1; k < NSTAGE; k++) begin : g_adv
    assign nxt[k] = st[k-1];
  end

  for (genvar k = 0; k < NSTAGE; k++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) st[k] <= '0;
      else        st[k] <= nxt[k];
    end
  end
endmodule

// File: rtl/ilk_regfile_wt.sv
module ilk_regfile_wt
  import ilk_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic [REG_W-1:0] rd_addr [NSRC],
  output logic [DW-1:0]    rd_data [NSRC]
);
  logic [DW-1:0] mem [NREGS];
  logic          wr_live;

  assign wr_live = wr_en && (wr_addr != '0);

  always_ff @(posedge clk) begin
    if (wr_live) mem[wr_addr] <= wr_data;
  end

  for (genvar p = 0; p < NSRC; p++) begin : g_rd
    always_comb begin
      if (rd_addr[p] == '0)                       rd_data[p] = '0;
      else if (wr_live && (wr_addr == rd_addr[p])) rd_data[p] = wr_data;
      else                                        rd_data[p] = mem[rd_addr[p]];
    end
  end
endmodule

// File: rtl/interlock_ctrl.sv
module interlock_ctrl
  import ilk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              id_valid,
  output logic              id_ready,
  input  logic [TAG_W-1:0]  id_tag,
  input  logic [REG_W-1:0]  id_rs1,
  input  logic              id_rs1_use,
  input  logic [REG_W-1:0]  id_rs2,
  input  logic              id_rs2_use,
  input  logic [REG_W-1:0]  id_rd,
  input  logic              id_we,
  input  logic              id_branch,
  input  logic [DATA_W-1:0] wb_data,
  output logic [DATA_W-1:0] rs1_data,
  output logic [DATA_W-1:0] rs2_data,
  output logic              stall,
  output logic              fetch_hold,
  output logic              ex_valid,
  output logic [TAG_W-1:0]  ex_tag,
  output logic              mem_valid,
  output logic [TAG_W-1:0]  mem_tag,
  output logic              wb_valid,
  output logic [TAG_W-1:0]  wb_tag
);
  logic [REG_W-1:0]  src_addr [NSRC];
  logic              src_use  [NSRC];
  logic [DATA_W-1:0] src_data [NSRC];
  stage_t            id_s;
  stage_t            st [NSTAGE];
  stage_t            ex_s, mem_s, wb_s;

  assign src_addr[0] = id_rs1;
  assign src_addr[1] = id_rs2;
  assign src_use[0]  = id_rs1_use;
  assign src_use[1]  = id_rs2_use;

  always_comb begin
    id_s.valid = id_valid;
    id_s.we    = id_we;
    id_s.rd    = id_rd;
    id_s.tag   = id_tag;
  end

  assign ex_s  = st[0];
  assign mem_s = st[1];
  assign wb_s  = st[2];

  ilk_hazard_detect u_haz (
    .id_valid (id_valid),
    .src_addr (src_addr),
    .src_use  (src_use),
    .ex_s     (ex_s),
    .mem_s    (mem_s),
    .stall    (stall)
  );

  ilk_stage_pipe u_pipe (
    .clk   (clk),
    .rst_n (rst_n),
    .stall (stall),
    .id_s  (id_s),
    .st    (st)
  );

  ilk_regfile_wt #(.DW(DATA_W)) u_rf (
    .clk     (clk),
    .wr_en   (wb_s.valid && wb_s.we),
    .wr_addr (wb_s.rd),
    .wr_data (wb_data),
    .rd_addr (src_addr),
    .rd_data (src_data)
  );

  assign rs1_data   = src_data[0];
  assign rs2_data   = src_data[1];
  assign id_ready   = !stall;
  assign fetch_hold = id_valid && id_branch;
  assign ex_valid   = ex_s.valid;
  assign ex_tag     = ex_s.tag;
  assign mem_valid  = mem_s.valid;
  assign mem_tag    = mem_s.tag;
  assign wb_valid   = wb_s.valid;
  assign wb_tag     = wb_s.tag;
endmodule

// File: rtl/ilk_checker.sv
module ilk_checker
  import ilk_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              id_valid,
  input logic [TAG_W-1:0]  id_tag,
  input logic [REG_W-1:0]  id_rs1,
  input logic              id_rs1_use,
  input logic              id_branch,
  input logic [DATA_W-1:0] rs1_data,
  input logic              stall,
  input logic              fetch_hold,
  input stage_t            ex_s,
  input stage_t            mem_s,
  input stage_t            wb_s
);
  // R1
  reset_clears_chk: assert property (@(posedge clk)
    !rst_n |=> !ex_s.valid && !mem_s.valid && !wb_s.valid);

  // R2
  ex_match_stalls_chk: assert property (@(posedge clk) disable iff (!rst_n)
    id_valid && id_rs1_use && id_rs1 != '0 && ex_s.valid && ex_s.we && ex_s.rd == id_rs1
    |-> stall);

  // R3
  mem_match_stalls_chk: assert property (@(posedge clk) disable iff (!rst_n)
    id_valid && id_rs1_use && id_rs1 != '0 && mem_s.valid && mem_s.we && mem_s.rd == id_rs1
    |-> stall);

  // R5
  zero_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    id_rs1 == '0 |-> rs1_data == '0);

  // R6
  bubble_after_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !ex_s.valid);

  // R6
  advance_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    id_valid && !stall |=> ex_s.valid && ex_s.tag == $past(id_tag));

  // R7
  branch_holds_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    id_valid && id_branch |-> fetch_hold);

  // R8
  ex_to_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ex_s.valid |=> mem_s.valid && mem_s.tag == $past(ex_s.tag));

  // R8
  mem_to_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_s.valid |=> wb_s.valid && wb_s.tag == $past(mem_s.tag));
endmodule

bind interlock_ctrl ilk_checker chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .id_valid   (id_valid),
  .id_tag     (id_tag),
  .id_rs1     (id_rs1),
  .id_rs1_use (id_rs1_use),
  .id_branch  (id_branch),
  .rs1_data   (rs1_data),
  .stall      (stall),
  .fetch_hold (fetch_hold),
  .ex_s       (ex_s),
  .mem_s      (mem_s),
  .wb_s       (wb_s)
);

// File: tb/interlock_ctrl_tb_top.sv
`timescale 1ns/1ps
module interlock_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        id_valid = 1'b0, id_rs1_use = 1'b0, id_rs2_use = 1'b0;
  logic        id_we = 1'b0, id_branch = 1'b0;
  logic [3:0]  id_tag = '0;
  logic [4:0]  id_rs1 = '0, id_rs2 = '0, id_rd = '0;
  logic [63:0] wb_data = '0;
  logic [63:0] rs1_data, rs2_data;
  logic        id_ready, stall, fetch_hold;
  logic        ex_valid, mem_valid, wb_valid;
  logic [3:0]  ex_tag, mem_tag, wb_tag;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  interlock_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id_ready(id_ready),
    .id_tag(id_tag), .id_rs1(id_rs1), .id_rs1_use(id_rs1_use),
    .id_rs2(id_rs2), .id_rs2_use(id_rs2_use), .id_rd(id_rd), .id_we(id_we),
    .id_branch(id_branch), .wb_data(wb_data), .rs1_data(rs1_data),
    .rs2_data(rs2_data), .stall(stall), .fetch_hold(fetch_hold),
    .ex_valid(ex_valid), .ex_tag(ex_tag), .mem_valid(mem_valid),
    .mem_tag(mem_tag), .wb_valid(wb_valid), .wb_tag(wb_tag)
  );

  // Row: decode program index(3) stall(1) fetch_hold(1) ex(3) mem(3) wb(3)
  // Loop: 1 load r2<-[r1]; 2 addi r3<-r2; 3 add r2<-r2,r3; 4 store r2->[r1];
  //       5 sub r4<-r1,r3; 6 branch on r4. Index 0 = empty slot.
  localparam int NROWS = 17;
  localparam logic [13:0] TBL [NROWS] = '{
    {3'd1, 1'b0, 1'b0, 3'd0, 3'd0, 3'd0},
    {3'd2, 1'b1, 1'b0, 3'd1, 3'd0, 3'd0},
    {3'd2, 1'b1, 1'b0, 3'd0, 3'd1, 3'd0},
    {3'd2, 1'b0, 1'b0, 3'd0, 3'd0, 3'd1},
    {3'd3, 1'b1, 1'b0, 3'd2, 3'd0, 3'd0},
    {3'd3, 1'b1, 1'b0, 3'd0, 3'd2, 3'd0},
    {3'd3, 1'b0, 1'b0, 3'd0, 3'd0, 3'd2},
    {3'd4, 1'b1, 1'b0, 3'd3, 3'd0, 3'd0},
    {3'd4, 1'b1, 1'b0, 3'd0, 3'd3, 3'd0},
    {3'd4, 1'b0, 1'b0, 3'd0, 3'd0, 3'd3},
    {3'd5, 1'b0, 1'b0, 3'd4, 3'd0, 3'd0},
    {3'd6, 1'b1, 1'b1, 3'd5, 3'd4, 3'd0},
    {3'd6, 1'b1, 1'b1, 3'd0, 3'd5, 3'd4},
    {3'd6, 1'b0, 1'b1, 3'd0, 3'd0, 3'd5},
    {3'd0, 1'b0, 1'b0, 3'd6, 3'd0, 3'd0},
    {3'd1, 1'b0, 1'b0, 3'd0, 3'd6, 3'd0},
    {3'd2, 1'b1, 1'b0, 3'd1, 3'd0, 3'd6}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [4:0] s1, input logic u1,
                       input logic [4:0] s2, input logic u2, input logic [4:0] d,
                       input logic w, input logic br, input logic [3:0] tg);
    id_valid = v; id_rs1 = s1; id_rs1_use = u1; id_rs2 = s2; id_rs2_use = u2;
    id_rd = d; id_we = w; id_branch = br; id_tag = tg;
  endtask

  task automatic drive_prog(input int idx);
    case (idx)
      1: drive(1, 5'd1, 1, 5'd0, 0, 5'd2, 1, 0, 4'd1);
      2: drive(1, 5'd2, 1, 5'd0, 0, 5'd3, 1, 0, 4'd2);
      3: drive(1, 5'd2, 1, 5'd3, 1, 5'd2, 1, 0, 4'd3);
      4: drive(1, 5'd1, 1, 5'd2, 1, 5'd0, 0, 0, 4'd4);
      5: drive(1, 5'd1, 1, 5'd3, 1, 5'd4, 1, 0, 4'd5);
      6: drive(1, 5'd4, 1, 5'd0, 0, 5'd0, 0, 1, 4'd6);
      default: drive(0, 5'd0, 0, 5'd0, 0, 5'd0, 0, 0, 4'd0);
    endcase
  endtask

  function automatic logic [3:0] occ(input logic v, input logic [3:0] t);
    return v ? t : 4'd0;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    drive_prog(0);
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    // R1: reset state
    do_reset();
    #1;
    chk("R1 ex_valid", ex_valid, 0);
    chk("R1 mem_valid", mem_valid, 0);
    chk("R1 wb_valid", wb_valid, 0);
    chk("R1 stall", stall, 0);
    chk("R1 fetch_hold", fetch_hold, 0);

    // Loop table: R2 R3 R6 R7 R8 R9 (store tag 4 has no destination)
    for (int r = 0; r < NROWS; r++) begin
      if (r != 0) @(negedge clk);
      drive_prog(int'(TBL[r][13:11]));
      #1;
      chk($sformatf("R2/R3 stall row %0d", r), stall, TBL[r][10]);
      chk($sformatf("R6 id_ready row %0d", r), id_ready, !TBL[r][10]);
      chk($sformatf("R7 fetch_hold row %0d", r), fetch_hold, TBL[r][9]);
      chk($sformatf("R6 ex row %0d", r), occ(ex_valid, ex_tag), TBL[r][8:6]);
      chk($sformatf("R8 mem row %0d", r), occ(mem_valid, mem_tag), TBL[r][5:3]);
      chk($sformatf("R8 wb row %0d", r), occ(wb_valid, wb_tag), TBL[r][2:0]);
    end

    // R1: reset with a full pipe
    @(negedge clk);
    rst_n = 1'b0;
    drive_prog(0);
    @(negedge clk);
    #1;
    chk("R1 ex cleared", ex_valid, 0);
    chk("R1 mem cleared", mem_valid, 0);
    chk("R1 wb cleared", wb_valid, 0);
    rst_n = 1'b1;

    // R2 R3 R4: producer r5 walked through the stages
    @(negedge clk);
    drive(1, 5'd0, 0, 5'd0, 0, 5'd5, 1, 0, 4'd7);
    @(negedge clk);
    drive(1, 5'd5, 1, 5'd0, 0, 5'd0, 0, 0, 4'd8);
    #1; chk("R2 ex match", stall, 1);
    @(negedge clk);
    #1; chk("R3 mem match", stall, 1);
    @(negedge clk);
    wb_data = 64'h0000_A5A5_0000_5A5A;
    #1; chk("R4 wb match no stall", stall, 0);
    chk("R4 write-through data", rs1_data, 64'h0000_A5A5_0000_5A5A);
    @(negedge clk);
    drive(1, 5'd0, 0, 5'd5, 1, 5'd0, 0, 0, 4'd9);
    wb_data = 64'h1234;
    #1; chk("R4 committed value", rs2_data, 64'h0000_A5A5_0000_5A5A);

    // R5: register 0 as destination and source
    do_reset();
    drive(1, 5'd0, 0, 5'd0, 0, 5'd0, 1, 0, 4'd1);
    @(negedge clk);
    drive(1, 5'd0, 1, 5'd0, 1, 5'd0, 0, 0, 4'd2);
    #1; chk("R5 r0 no stall", stall, 0);
    chk("R5 r0 reads zero", rs1_data, 0);

    // R9: no write enable, no stall
    do_reset();
    drive(1, 5'd0, 0, 5'd0, 0, 5'd6, 0, 0, 4'd3);
    @(negedge clk);
    drive(1, 5'd6, 1, 5'd6, 1, 5'd0, 0, 0, 4'd4);
    #1; chk("R9 store dest ignored", stall, 0);

    // R10: unused sources ignored, then used rs2 stalls
    do_reset();
    drive(1, 5'd0, 0, 5'd0, 0, 5'd7, 1, 0, 4'd5);
    @(negedge clk);
    drive(1, 5'd7, 0, 5'd7, 0, 5'd0, 0, 0, 4'd6);
    #1; chk("R10 unused sources", stall, 0);
    id_rs2_use = 1'b1;
    #1; chk("R2 rs2 ex match", stall, 1);

    // R7: branch flag without a valid instruction
    do_reset();
    drive(0, 5'd0, 0, 5'd0, 0, 5'd0, 0, 1, 4'd0);
    #1; chk("R7 invalid branch", fetch_hold, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule